// File: doc/BRIEF.md
# UART Transmit Clear-to-Send Handshake and Change Interrupt

This block sits between a UART's transmit queue and its bit serializer. It watches the far end's active-low clear-to-send line, which arrives asynchronously. When hardware flow control is on, it withholds the start of each new character while that line is inactive. It lets transmission continue on its own once the line returns. Software never has to change the transmit-enable bit to pause or resume the link. That removes the failure in which a short clear-to-send glitch leaves the transmitter disabled for good.

The block also keeps a sticky status bit that records every change of the clear-to-send level. Deassertion and reassertion each count as a separate event. The block keeps an interrupt-enable bit for that status, a write-one-to-clear address and an interrupt output. A small register port gives access to the control bits, the interrupt register, the clear address and a status word. The status word shows the synchronized clear-to-send level and a transmitter busy flag.

Register map (word addresses on `reg_addr`):
- Address 0: control register. Bit 8 is the transmit enable and bit 14 turns hardware flow control on. Both read back.
- Address 1: interrupt register. Enable bits sit in the upper half and status bits in the lower half. Bit 17 is the change-interrupt enable (read/write). Bit 1 is the change status, and it is read-only at this address.
- Address 2: clear address. A write with bit 1 set clears the change status. This address reads as zero.
- Address 3: status register (read-only). Bit 29 is the busy flag and bit 28 reads 1 while clear-to-send is active.

Read data is registered and appears one clock after the address.

Top module: `uart_cts_flow`

## Requirements
- R1: A change of `cts_n_async` in either direction, held for at least three clocks, sets the change status (interrupt register bit 1) no later than the third rising edge after the change. A deassertion and the reassertion that follows are separate events, and each one sets the bit again after a clear.
- R2: The change status sets even while its enable (interrupt register bit 17) is zero. `cts_irq` is high exactly when the status and the enable are both set.
- R3: Writing a word with bit 1 set to the clear address (2) clears the change status. A write to that address with bit 1 at zero leaves the status unchanged.
- R4: When a clock edge both detects a change and applies a clear write, the status ends up set.
- R5: With hardware flow control on (control bit 14 = 1), no `tx_start` is issued while the synchronized clear-to-send is inactive (`cts_n_async` high). Queued characters start again without any register write once the line is active again.
- R6: With the transmit enable (control bit 8) at zero, no `tx_start` is issued, whatever the clear-to-send level or the flow-control mode.
- R7: `tx_start` is a single-cycle pulse and is never issued while `tx_busy` is high. A character already under way finishes even if clear-to-send drops during it.
- R8: With hardware flow control off, the clear-to-send level has no effect on when characters start, but its changes are still recorded in the change status.
- R9: Status register bit 29 is high while a character is in progress or queued and allowed to start. It falls to 0 once the serializer is idle and nothing is allowed to start. Bit 28 reads 1 while clear-to-send is active.
- R10: After reset the control register and the interrupt register read zero, and `cts_irq` and `tx_start` are low.
- R11: A train of inactive clear-to-send pulses, each three clocks wide, applied while characters are flowing, neither stalls the transmitter for good nor leaves the change status impossible to clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cts_n_async | input | 1 | Clear-to-send from the far end, active low, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data for `reg_addr` |
| tx_valid | input | 1 | A character is queued for transmission |
| tx_busy | input | 1 | Serializer is shifting a character out |
| tx_start | output | 1 | One-cycle request to start the next character |
| cts_irq | output | 1 | Clear-to-send change interrupt |

## Verification
The bench builds the block with its defaults: a two-stage synchronizer and a 32-bit register port. With these defaults the worst-case path from a line change to the status bit is three clocks. That makes a three-clock pulse the shortest one that still has to give two events, and the bench drives trains of such pulses. The serializer stub in the bench holds `tx_busy` for twenty clocks per character. This puts a clear-to-send drop inside a character within reach, and it allows a clear write to be lined up on the exact cycle the synchronized edge lands.

// File: rtl/uart_cts_pkg.sv
package uart_cts_pkg;
  // register word addresses
  localparam int ADDR_CTRL = 0;
  localparam int ADDR_INTR = 1;
  localparam int ADDR_ICLR = 2;
  localparam int ADDR_STAT = 3;

  // bit positions
  localparam int CTRL_TXEN_BIT = 8;
  localparam int CTRL_HWFC_BIT = 14;
  localparam int INTR_EN_OFS   = 16;
  localparam int INTR_CHG_BIT  = 1;
  localparam int INTR_CHG_EN   = INTR_EN_OFS + INTR_CHG_BIT;
  localparam int STAT_CTS_BIT  = 28;
  localparam int STAT_BUSY_BIT = 29;

  typedef struct packed {
    logic hwfc;
    logic txen;
  } tx_ctrl_t;
endpackage

// File: rtl/cts_sync_edge.sv
module cts_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cts_n_async,
  output logic cts_active,
  output logic cts_edge
);
  localparam int TOP = STAGES - 1;

  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], cts_n_async};
      last_q  <= chain_q[TOP];
    end
  end

  assign cts_edge   = chain_q[TOP] ^ last_q;
  assign cts_active = ~chain_q[TOP];

  initial begin
    AST_SYNC_DEPTH: assert (STAGES >= 2); // R1
  end
endmodule

// File: rtl/cts_status.sv
module cts_status (
  input  logic clk,
  input  logic rst,
  input  logic edge_i,
  input  logic clr_i,
  input  logic en_wr_i,
  input  logic en_d_i,
  output logic status_o,
  output logic enable_o,
  output logic irq_o
);
  logic status_n, enable_n;

  always_comb begin
    status_n = edge_i | (status_o & ~clr_i);
    enable_n = en_wr_i ? en_d_i : enable_o;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_o <= 1'b0;
      enable_o <= 1'b0;
      irq_o    <= 1'b0;
    end else begin
      status_o <= status_n;
      enable_o <= enable_n;
      irq_o    <= status_n & enable_n;
    end
  end

  AST_EDGE_RECORDED: assert property (@(posedge clk) disable iff (rst)
    edge_i |=> status_o); // R1
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (status_o && enable_o)); // R2
  AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!edge_i && !clr_i) |=> $stable(status_o)); // R2
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !edge_i) |=> !status_o); // R3
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (edge_i && clr_i) |=> status_o); // R4
endmodule

// File: rtl/tx_gate.sv
module tx_gate (
  input  logic clk,
  input  logic rst,
  input  logic txen_i,
  input  logic hwfc_i,
  input  logic cts_active_i,
  input  logic tx_valid_i,
  input  logic tx_busy_i,
  output logic tx_start_o,
  output logic busy_flag_o
);
  logic allowed;

  assign allowed = txen_i & (~hwfc_i | cts_active_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_start_o  <= 1'b0;
      busy_flag_o <= 1'b0;
    end else begin
      tx_start_o  <= tx_valid_i & allowed & ~tx_busy_i & ~tx_start_o;
      busy_flag_o <= tx_busy_i | tx_start_o | (tx_valid_i & allowed);
    end
  end

  AST_START_NEEDS_CTS: assert property (@(posedge clk) disable iff (rst)
    (tx_start_o && $past(hwfc_i)) |-> $past(cts_active_i)); // R5
  AST_START_NEEDS_TXEN: assert property (@(posedge clk) disable iff (rst)
    tx_start_o |-> $past(txen_i)); // R6
  AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    tx_start_o |-> !$past(tx_busy_i)); // R7
  AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
    tx_start_o |=> !tx_start_o); // R7
  AST_BUSY_FALLS: assert property (@(posedge clk) disable iff (rst)
    $past(!tx_busy_i && !tx_start_o && !tx_valid_i) |-> !busy_flag_o); // R9
endmodule

// File: rtl/uart_cts_flow.sv
module uart_cts_flow
  import uart_cts_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cts_n_async,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              tx_valid,
  input  logic              tx_busy,
  output logic              tx_start,
  output logic              cts_irq
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADDR_CTRL);
  localparam logic [ADDR_W-1:0] A_INTR = ADDR_W'(ADDR_INTR);
  localparam logic [ADDR_W-1:0] A_ICLR = ADDR_W'(ADDR_ICLR);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADDR_STAT);

  tx_ctrl_t ctrl_q;
  logic     cts_active, cts_edge;
  logic     chg_status, chg_enable;
  logic     clr_hit, en_wr;
  logic     busy_flag;
  logic     unused_wdata;

  assign unused_wdata = ^reg_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (reg_wr && reg_addr == A_CTRL) begin
      ctrl_q.txen <= reg_wdata[CTRL_TXEN_BIT];
      ctrl_q.hwfc <= reg_wdata[CTRL_HWFC_BIT];
    end
  end

  assign clr_hit = reg_wr && (reg_addr == A_ICLR) && reg_wdata[INTR_CHG_BIT];
  assign en_wr   = reg_wr && (reg_addr == A_INTR);

  cts_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk         (clk),
    .rst         (rst),
    .cts_n_async (cts_n_async),
    .cts_active  (cts_active),
    .cts_edge    (cts_edge)
  );

  cts_status u_status (
    .clk      (clk),
    .rst      (rst),
    .edge_i   (cts_edge),
    .clr_i    (clr_hit),
    .en_wr_i  (en_wr),
    .en_d_i   (reg_wdata[INTR_CHG_EN]),
    .status_o (chg_status),
    .enable_o (chg_enable),
    .irq_o    (cts_irq)
  );

  tx_gate u_gate (
    .clk          (clk),
    .rst          (rst),
    .txen_i       (ctrl_q.txen),
    .hwfc_i       (ctrl_q.hwfc),
    .cts_active_i (cts_active),
    .tx_valid_i   (tx_valid),
    .tx_busy_i    (tx_busy),
    .tx_start_o   (tx_start),
    .busy_flag_o  (busy_flag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      reg_rdata <= '0;
      case (reg_addr)
        A_CTRL: begin
          reg_rdata[CTRL_TXEN_BIT] <= ctrl_q.txen;
          reg_rdata[CTRL_HWFC_BIT] <= ctrl_q.hwfc;
        end
        A_INTR: begin
          reg_rdata[INTR_CHG_EN]  <= chg_enable;
          reg_rdata[INTR_CHG_BIT] <= chg_status;
        end
        A_STAT: begin
          reg_rdata[STAT_BUSY_BIT] <= busy_flag;
          reg_rdata[STAT_CTS_BIT]  <= cts_active;
        end
        default: reg_rdata <= '0;
      endcase
    end
  end

  AST_ZERO_CLEAR_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == A_ICLR && !reg_wdata[INTR_CHG_BIT] && chg_status)
      |=> chg_status); // R3
  AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q.txen && !$past(ctrl_q.txen)) |-> !tx_start); // R6
endmodule

// File: tb/uart_cts_flow_bench.sv
module uart_cts_flow_bench;
  localparam int CHAR_CYC = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cts_n = 1'b0;
  logic        wr = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        tx_valid, tx_busy, tx_start, irq;

  int queued = 0;
  int starts = 0;
  int busy_cnt = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  assign tx_valid = queued > starts;
  assign tx_busy  = busy_cnt != 0;

  // serializer stub
  always @(posedge clk) begin
    if (rst) begin
      busy_cnt <= 0;
    end else if (tx_start) begin
      starts   <= starts + 1;
      busy_cnt <= CHAR_CYC;
    end else if (busy_cnt != 0) begin
      busy_cnt <= busy_cnt - 1;
    end
  end

  uart_cts_flow u_uart_cts_flow (
    .clk(clk), .rst(rst), .cts_n_async(cts_n),
    .reg_wr(wr), .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata),
    .tx_valid(tx_valid), .tx_busy(tx_busy), .tx_start(tx_start),
    .cts_irq(irq)
  );

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] v);
    addr = a;
    @(negedge clk);
    v = rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd_reg(2'd0, v); check(v == 32'h0, "R10 ctrl", v, 32'h0);
    rd_reg(2'd1, v); check(v == 32'h0, "R10 intr", v, 32'h0);
    check(irq == 1'b0, "R10 irq", irq, 0);
    check(tx_start == 1'b0, "R10 start", tx_start, 0);
  endtask

  task automatic t_edges();
    logic [31:0] v;
    cts_n = 1'b1; cycles(4);
    rd_reg(2'd1, v); check(v == 32'h2, "R1 deassert event", v, 32'h2);
    check(irq == 1'b0, "R2 irq masked", irq, 0);
    wr_reg(2'd1, 32'h0002_0000); cycles(1);
    check(irq == 1'b1, "R2 irq enabled", irq, 1);
    wr_reg(2'd2, 32'h2);
    rd_reg(2'd1, v); check(v == 32'h0002_0000, "R3 clear", v, 32'h0002_0000);
    check(irq == 1'b0, "R2 irq after clear", irq, 0);
    cts_n = 1'b0; cycles(4);
    rd_reg(2'd1, v); check(v == 32'h0002_0002, "R1 reassert event", v, 32'h0002_0002);
    wr_reg(2'd2, 32'hFFFF_FFFD);
    rd_reg(2'd1, v); check(v == 32'h0002_0002, "R3 zero bit ignored", v, 32'h0002_0002);
    check(irq == 1'b1, "R2 irq held", irq, 1);
    wr_reg(2'd1, 32'h0);
  endtask

  task automatic t_set_wins();
    logic [31:0] v;
    cts_n = 1'b1; cycles(4);          // status set beforehand
    cts_n = 1'b0; cycles(2);
    wr_reg(2'd2, 32'h2);              // clear lands with the edge
    rd_reg(2'd1, v); check(v == 32'h2, "R4 set beats clear", v, 32'h2);
    wr_reg(2'd2, 32'h2);
    rd_reg(2'd1, v); check(v == 32'h0, "R3 clear later", v, 32'h0);
  endtask

  task automatic t_hwfc();
    logic [31:0] v;
    int base;
    wr_reg(2'd0, 32'h4100);
    base = starts;
    queued += 3;
    cycles(5);
    check(starts == base + 1, "R5 first start", starts, base + 1);
    rd_reg(2'd3, v); check(v == 32'h3000_0000, "R9 busy with cts", v, 32'h3000_0000);
    cts_n = 1'b1; cycles(60);
    check(starts == base + 1, "R5 held while inactive", starts, base + 1);
    check(tx_busy == 1'b0, "R7 char completed", tx_busy, 0);
    rd_reg(2'd3, v); check(v == 32'h0, "R9 idle when blocked", v, 32'h0);
    cts_n = 1'b0; cycles(80);
    check(starts == base + 3, "R5 auto resume", starts, base + 3);
    rd_reg(2'd3, v); check(v == 32'h1000_0000, "R9 busy falls", v, 32'h1000_0000);
    wr_reg(2'd2, 32'h2);
  endtask

  task automatic t_txen();
    int base;
    wr_reg(2'd0, 32'h4000);
    base = starts;
    queued += 1;
    cycles(40);
    check(starts == base, "R6 no start when disabled", starts, base);
    wr_reg(2'd0, 32'h0100);
    cycles(5);
    check(starts == base + 1, "R6 start after enable", starts, base + 1);
    cycles(30);
  endtask

  task automatic t_nofc();
    logic [31:0] v;
    int base;
    wr_reg(2'd2, 32'h2);
    wr_reg(2'd0, 32'h0100);
    cts_n = 1'b1;
    base = starts;
    queued += 2;
    cycles(80);
    check(starts == base + 2, "R8 cts ignored", starts, base + 2);
    rd_reg(2'd1, v); check(v == 32'h2, "R8 change recorded", v, 32'h2);
    cts_n = 1'b0; cycles(4);
    wr_reg(2'd2, 32'h2);
  endtask

  task automatic t_glitch();
    logic [31:0] v;
    int base;
    wr_reg(2'd0, 32'h4100);
    base = starts;
    queued += 5;
    for (int i = 0; i < 20; i++) begin
      cts_n = 1'b1; cycles(3);
      cts_n = 1'b0; cycles(7);
    end
    rd_reg(2'd1, v); check(v == 32'h2, "R11 pulses recorded", v, 32'h2);
    cycles(200);
    check(starts == base + 5, "R11 all sent", starts, base + 5);
    rd_reg(2'd3, v); check(v == 32'h1000_0000, "R11 not stuck busy", v, 32'h1000_0000);
    wr_reg(2'd2, 32'h2);
    rd_reg(2'd1, v); check(v == 32'h0, "R11 status clearable", v, 32'h0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    cycles(5);
    rst = 1'b0;
    cycles(2);
    t_reset();
    t_edges();
    t_set_wins();
    t_hwfc();
    t_txen();
    t_nofc();
    t_glitch();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end
endmodule